// File: doc/BRIEF.md
# Outstanding Write ID Allocator

This block sits on the master side of a memory-mapped bus. It gives each new write request a transaction ID, so that no two writes in flight at the same time share an ID. A requester raises `req_valid`. The allocator presents a free ID on `req_id` together with `req_ready`, and the ID counts as taken in the cycle where both signals are high. The pool holds 2^ID_W IDs and always offers the lowest-numbered free one. When every ID is taken, `req_ready` stays low and new requests wait.

Write responses come in on the response port as an ID plus a status code, and they may arrive in any order. A response for an ID that is in use frees that ID. One cycle later it is reported on the completion port with the same ID and status. A response for an ID that is not in use changes nothing and raises a single-cycle error flag instead. Because IDs in flight are always distinct, each completion matches exactly one outstanding write, whichever slave answers first. The number of outstanding IDs is always available on `busy_count`.

Top module: `wr_id_alloc`

## Requirements
- R1: After a synchronous active-high reset, no ID is in use: `req_ready`=1, `req_id`=0, `busy_count`=0, and `cpl_valid` and `err_pulse` are 0.
- R2: While `req_ready` is 1, `req_id` holds the lowest-numbered ID that is not in use. A cycle with `req_valid`=1 and `req_ready`=1 takes that ID.
- R3: An ID that has been taken is not offered again until a response for it has been accepted.
- R4: When all 2^ID_W IDs are in use, `req_ready` is 0 and a request takes nothing.
- R5: A response for an ID in use frees it at that clock edge. `req_ready` and `req_id` reflect the freed ID in the very next cycle, so the ID can be taken again from that cycle on.
- R6: One cycle after a response for an ID in use, `cpl_valid` is 1 for exactly one cycle, and `cpl_id` and `cpl_resp` equal the response's ID and status. This holds for responses in any order.
- R7: A grant and a release in the same cycle both take effect, and `busy_count` is unchanged.
- R8: A response for an ID not in use raises `err_pulse` for one cycle after it. It produces no completion and does not change which IDs are in use.
- R9: `busy_count` equals the number of IDs in use, updated in the cycle after each grant or release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Requester wants a write ID |
| req_ready | output | 1 | A free ID is on offer |
| req_id | output | ID_W | ID granted on handshake |
| rsp_valid | input | 1 | A write response is present |
| rsp_id | input | ID_W | ID of the response |
| rsp_resp | input | RESP_W | Status of the response |
| cpl_valid | output | 1 | Completion pulse |
| cpl_id | output | ID_W | ID of the completed write |
| cpl_resp | output | RESP_W | Status of the completed write |
| err_pulse | output | 1 | Response arrived for an ID not in use |
| busy_count | output | ID_W+1 | Number of IDs in use |

## Verification
The pool is first filled by back-to-back requests. This shows that the lowest-ID choice runs upward and that the stall begins at exactly 2^ID_W IDs. Responses then arrive in a shuffled order, which separates correct matching by ID from any issue-order assumption and shows that a freed ID in the middle of the range is the next one offered. Cycles that grant and release together test that both updates are applied. Responses for IDs not in use test that the error path leaves the pool and the completion port untouched.

// File: rtl/wia_pkg.sv
package wia_pkg;
  // Classification of an incoming write response
  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_CPL  = 2'd1,
    EV_ERR  = 2'd2
  } rsp_ev_e;
endpackage

// File: rtl/wia_free_pick.sv
module wia_free_pick #(
  parameter int ID_W = 3
) (
  input  logic [(1<<ID_W)-1:0] busy,
  output logic                 any_free,
  output logic [ID_W-1:0]      pick
);
  localparam int POOL = 1 << ID_W;

  // Scan from the top down so the lowest free index wins
  always_comb begin
    any_free = 1'b0;
    pick     = '0;
    for (int i = POOL - 1; i >= 0; i--) begin
      if (!busy[i]) begin
        any_free = 1'b1;
        pick     = ID_W'(i);
      end
    end
  end
endmodule

// File: rtl/wia_busy_pool.sv
module wia_busy_pool #(
  parameter int ID_W = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 set_en,
  input  logic [ID_W-1:0]      set_id,
  input  logic                 clr_en,
  input  logic [ID_W-1:0]      clr_id,
  output logic [(1<<ID_W)-1:0] busy,
  output logic [(1<<ID_W)-1:0] busy_d
);
  localparam int POOL = 1 << ID_W;

  for (genvar g = 0; g < POOL; g++) begin : g_bit
    logic hit_set, hit_clr;
    assign hit_set   = set_en && (set_id == ID_W'(g));
    assign hit_clr   = clr_en && (clr_id == ID_W'(g));
    assign busy_d[g] = (busy[g] && !hit_clr) || hit_set;

    always_ff @(posedge clk) begin
      if (rst) busy[g] <= 1'b0;
      else     busy[g] <= busy_d[g];
    end
  end

  // R3
  grant_free_chk: assert property (@(posedge clk) disable iff (rst)
    set_en |-> !busy[set_id]);

  // R5
  release_held_chk: assert property (@(posedge clk) disable iff (rst)
    clr_en |-> busy[clr_id]);
endmodule

// File: rtl/wr_id_alloc.sv
module wr_id_alloc #(
  parameter int ID_W   = 3,
  parameter int RESP_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  output logic [ID_W-1:0]   req_id,
  input  logic              rsp_valid,
  input  logic [ID_W-1:0]   rsp_id,
  input  logic [RESP_W-1:0] rsp_resp,
  output logic              cpl_valid,
  output logic [ID_W-1:0]   cpl_id,
  output logic [RESP_W-1:0] cpl_resp,
  output logic              err_pulse,
  output logic [ID_W:0]     busy_count
);
  import wia_pkg::*;

  localparam int POOL  = 1 << ID_W;
  localparam int CNT_W = ID_W + 1;

  logic [POOL-1:0] busy, busy_d;
  logic            grant, nxt_free;
  logic [ID_W-1:0] nxt_pick;
  rsp_ev_e         ev;

  assign grant = req_valid && req_ready;

  always_comb begin
    ev = EV_NONE;
    if (rsp_valid) ev = busy[rsp_id] ? EV_CPL : EV_ERR;
  end

  wia_busy_pool #(.ID_W(ID_W)) u_pool (
    .clk    (clk),
    .rst    (rst),
    .set_en (grant),
    .set_id (req_id),
    .clr_en (ev == EV_CPL),
    .clr_id (rsp_id),
    .busy   (busy),
    .busy_d (busy_d)
  );

  // Choose from the next-state bits so the offer is registered
  wia_free_pick #(.ID_W(ID_W)) u_pick (
    .busy     (busy_d),
    .any_free (nxt_free),
    .pick     (nxt_pick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      req_ready  <= 1'b1;
      req_id     <= '0;
      busy_count <= '0;
      cpl_valid  <= 1'b0;
      cpl_id     <= '0;
      cpl_resp   <= '0;
      err_pulse  <= 1'b0;
    end else begin
      req_ready  <= nxt_free;
      req_id     <= nxt_pick;
      busy_count <= CNT_W'($countones(busy_d));
      cpl_valid  <= (ev == EV_CPL);
      err_pulse  <= (ev == EV_ERR);
      if (ev == EV_CPL) begin
        cpl_id   <= rsp_id;
        cpl_resp <= rsp_resp;
      end
    end
  end

  // R2
  offer_free_chk: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !busy[req_id]);

  // R4
  full_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (&busy) |-> !req_ready);

  // R6
  cpl_freed_chk: assert property (@(posedge clk) disable iff (rst)
    cpl_valid |-> !busy[cpl_id]);

  // R8
  err_excl_chk: assert property (@(posedge clk) disable iff (rst)
    err_pulse |-> !cpl_valid);

  // R9
  count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    busy_count <= CNT_W'(POOL));
endmodule

// File: tb/wr_id_alloc_bench.sv
module wr_id_alloc_bench;
  localparam int ID_W   = 3;
  localparam int RESP_W = 2;
  localparam int POOL   = 1 << ID_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, rsp_valid = 1'b0;
  logic [ID_W-1:0] rsp_id = '0;
  logic [RESP_W-1:0] rsp_resp = '0;
  logic req_ready, cpl_valid, err_pulse;
  logic [ID_W-1:0] req_id, cpl_id;
  logic [RESP_W-1:0] cpl_resp;
  logic [ID_W:0] busy_count;

  int total = 0, bad = 0;
  logic [POOL-1:0] mbusy = '0;
  logic [ID_W+RESP_W-1:0] exp_q[$];
  logic exp_err = 1'b0;

  always #5 clk = ~clk;

  wr_id_alloc #(.ID_W(ID_W), .RESP_W(RESP_W)) u_wr_id_alloc (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_id(req_id), .rsp_valid(rsp_valid), .rsp_id(rsp_id),
    .rsp_resp(rsp_resp), .cpl_valid(cpl_valid), .cpl_id(cpl_id),
    .cpl_resp(cpl_resp), .err_pulse(err_pulse), .busy_count(busy_count)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int low_free(input logic [POOL-1:0] b);
    for (int i = 0; i < POOL; i++) if (!b[i]) return i;
    return 0;
  endfunction

  // Monitor: pops expected completions as the design reports them
  always @(negedge clk) begin
    if (!rst) begin
      if (cpl_valid) begin
        if (exp_q.size() == 0) chk("R6 unexpected completion", 1, 0);
        else begin
          logic [ID_W+RESP_W-1:0] e;
          e = exp_q.pop_front();
          chk("R6 completion id", int'(cpl_id), int'(e[ID_W+RESP_W-1:RESP_W]));
          chk("R6 completion resp", int'(cpl_resp), int'(e[RESP_W-1:0]));
        end
      end
      chk("R8 error pulse", int'(err_pulse), int'(exp_err));
    end
  end

  // Driver: one cycle, starting and ending just after a falling edge
  task automatic step(input logic rv, input logic sv,
                      input logic [ID_W-1:0] sid, input logic [RESP_W-1:0] sr);
    logic full;
    logic [ID_W-1:0] gid;
    full = &mbusy;
    chk("R4 ready vs pool", int'(req_ready), int'(!full));
    if (!full) chk("R2 lowest free id", int'(req_id), low_free(mbusy));
    chk("R9 busy count", int'(busy_count), $countones(mbusy));
    gid = req_id;
    req_valid = rv; rsp_valid = sv; rsp_id = sid; rsp_resp = sr;
    @(posedge clk);
    #1;
    exp_err = 1'b0;
    if (sv) begin
      if (mbusy[sid]) begin
        mbusy[sid] = 1'b0;
        exp_q.push_back({sid, sr});
      end else exp_err = 1'b1;
    end
    if (rv && !full) mbusy[gid] = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; rsp_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 ready", int'(req_ready), 1);
    chk("R1 id", int'(req_id), 0);
    chk("R1 count", int'(busy_count), 0);
    chk("R1 cpl", int'(cpl_valid), 0);
    chk("R1 err", int'(err_pulse), 0);
    // R2/R3 fill the pool with back-to-back requests
    for (int i = 0; i < POOL; i++) step(1'b1, 1'b0, '0, '0);
    // R4 request while full takes nothing
    step(1'b1, 1'b0, '0, '0);
    step(1'b1, 1'b0, '0, '0);
    // R5/R6 out-of-order release of id 5, then regrant
    step(1'b0, 1'b1, 3'd5, 2'd2);
    chk("R5 ready after release", int'(req_ready), 1);
    chk("R5 freed id offered", int'(req_id), 5);
    step(1'b1, 1'b0, '0, '0);
    // R6 more releases in shuffled order
    step(1'b0, 1'b1, 3'd6, 2'd1);
    step(1'b0, 1'b1, 3'd1, 2'd3);
    step(1'b0, 1'b1, 3'd3, 2'd0);
    // R7 grant and release together keep count
    chk("R7 count before", int'(busy_count), 5);
    step(1'b1, 1'b1, 3'd0, 2'd1);
    chk("R7 count after", int'(busy_count), 5);
    chk("R7 next offer", int'(req_id), 0);
    // R8 response for an ID not in use
    step(1'b0, 1'b1, 3'd3, 2'd2);
    chk("R8 count unchanged", int'(busy_count), 5);
    step(1'b0, 1'b1, 3'd0, 2'd0);
    // drain remaining IDs in descending order
    for (int i = POOL - 1; i >= 0; i--) step(1'b0, 1'b1, ID_W'(i), RESP_W'(i));
    step(1'b0, 1'b0, '0, '0);
    chk("R9 drained count", int'(busy_count), 0);
    chk("R6 all completions seen", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule